// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block sits beside a 32-bit integer datapath and owns two special result registers, called HI and LO here. Software cannot reach them as general registers. They change only through multiply, divide and move-to commands, and they are read only through move-from commands. A command is a single-cycle pulse on `cmd_valid` with a 6-bit function code and two source operands, `op_a` (the first source) and `op_b` (the second source).

Multiply and divide run iteratively: one shift-add or restoring-subtract step per clock for 32 steps, then one finishing cycle that fixes the signs and writes HI and LO. `busy` is high for the whole operation. A move-from command that arrives during an operation is held back. It is answered in the finishing cycle with the newly written value. The unit has four states:

- `ST_IDLE` accepts commands.
- `ST_MUL` and `ST_DIV` each run 32 steps.
- `ST_FIN` writes the results and returns to `ST_IDLE`.

The transitions are:

- `ST_IDLE` goes to `ST_MUL` on an accepted multiply, and to `ST_DIV` on an accepted divide.
- `ST_MUL` and `ST_DIV` go to `ST_FIN` after the last step.
- `ST_FIN` goes to `ST_IDLE` unconditionally.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI and LO are zero, `busy` is 0 and `rd_valid` is 0.
- R2: Function 011000 (signed multiply) forms the 64-bit two's-complement product of `op_a` and `op_b`. The upper 32 bits go to HI and the lower 32 bits go to LO.
- R3: Function 011001 (unsigned multiply) forms the 64-bit unsigned product, split across HI and LO in the same way as R2.
- R4: Function 011010 (signed divide) puts the quotient `op_a/op_b` in LO and the remainder in HI. The quotient truncates toward zero and the remainder takes the sign of the dividend. The case 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: Function 011011 (unsigned divide) puts the unsigned quotient in LO and the unsigned remainder in HI.
- R6: A divide with `op_b` equal to zero completes normally and leaves LO = 0xFFFFFFFF and HI equal to `op_a`. This holds for both signed and unsigned divide.
- R7: Functions 010001 and 010011 copy `op_a` into HI and LO respectively. Functions 010000 and 010010 return HI and LO respectively on `rd_data`, with `rd_valid` high on the following cycle.
- R8: From the cycle after a multiply or divide is accepted, `busy` stays high for exactly 33 cycles.
- R9: A move-from command issued while `busy` is high is answered with `rd_valid` in the finishing cycle. It returns the value written by the running operation.
- R10: Multiply, divide and move-to commands issued while `busy` is high have no effect on HI or LO.
- R11: A function code outside the eight listed in R2 to R7 changes neither HI nor LO, and produces no `rd_valid`.
- R12: With no command and `busy` low, HI and LO hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_func | input | 6 | Function code |
| op_a | input | 32 | First source operand (dividend / move-to data) |
| op_b | input | 32 | Second source operand (divisor / multiplier) |
| rd_data | output | 32 | Move-from result |
| rd_valid | output | 1 | `rd_data` holds a move-from result this cycle |
| busy | output | 1 | A multiply or divide is in progress |

## Verification
The multiply is tried with operands of mixed signs, with all-ones operands and with the most negative value. These separate the signed and unsigned codes, whose low halves agree but whose high halves differ. The divide is tried with all four sign combinations, so that truncation direction and remainder sign are each pinned down. It is also tried with a zero divisor and with the most-negative by minus-one case. Reads and writes issued during an operation show whether a move-from is delayed until the new value exists, and whether other commands really leave HI and LO untouched.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
    localparam logic [5:0] F_MFHI  = 6'b010000;
    localparam logic [5:0] F_MTHI  = 6'b010001;
    localparam logic [5:0] F_MFLO  = 6'b010010;
    localparam logic [5:0] F_MTLO  = 6'b010011;
    localparam logic [5:0] F_MULT  = 6'b011000;
    localparam logic [5:0] F_MULTU = 6'b011001;
    localparam logic [5:0] F_DIV   = 6'b011010;
    localparam logic [5:0] F_DIVU  = 6'b011011;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2,
        ST_FIN  = 2'd3
    } mdu_state_t;
endpackage

// File: rtl/hilo_mul_step.sv
// One shift-add multiply step: upper half accumulates, lower half holds
// the remaining multiplier bits.
module hilo_mul_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] work_i,
    input  logic [W-1:0]   mcand_i,
    output logic [2*W-1:0] work_o
);
    logic [W:0] sum;

    always_comb begin
        sum    = {1'b0, work_i[2*W-1:W]} + (work_i[0] ? {1'b0, mcand_i} : '0);
        work_o = {sum, work_i[W-1:1]};
    end
endmodule

// File: rtl/hilo_div_step.sv
// One restoring-divide step: upper half is the partial remainder, lower
// half shifts dividend bits out and quotient bits in.
module hilo_div_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] work_i,
    input  logic [W-1:0]   dvsr_i,
    output logic [2*W-1:0] work_o
);
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        shifted = {work_i[2*W-1:W], work_i[W-1]};
        diff    = shifted - {1'b0, dvsr_i};
        if (!diff[W])
            work_o = {diff[W-1:0], work_i[W-2:0], 1'b1};
        else
            work_o = {shifted[W-1:0], work_i[W-2:0], 1'b0};
    end
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import hilo_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [5:0]   cmd_func,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         busy
);
    localparam int CW = $clog2(W);

    mdu_state_t      state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [W-1:0]    opnd_q, orig_q, hi_q, lo_q;
    logic [2*W-1:0]  work_q, mul_nxt, div_nxt, prod;
    logic            neg_lo_q, neg_hi_q, dz_q, is_div_q, pend_q, pend_hi_q;

    // command decode
    logic            is_mul, is_dv, sgn, mf_any, mf_hi, accept, sign_x;
    logic [W-1:0]    abs_a, abs_b, quo, rem, fin_hi, fin_lo;

    always_comb begin
        is_mul = (cmd_func == F_MULT) || (cmd_func == F_MULTU);
        is_dv  = (cmd_func == F_DIV)  || (cmd_func == F_DIVU);
        sgn    = (cmd_func == F_MULT) || (cmd_func == F_DIV);
        mf_hi  = (cmd_func == F_MFHI);
        mf_any = mf_hi || (cmd_func == F_MFLO);
        accept = cmd_valid && (state_q == ST_IDLE);
        sign_x = sgn && (op_a[W-1] ^ op_b[W-1]);
        abs_a  = (sgn && op_a[W-1]) ? -op_a : op_a;
        abs_b  = (sgn && op_b[W-1]) ? -op_b : op_b;
    end

    hilo_mul_step #(.W(W)) u_mul (.work_i(work_q), .mcand_i(opnd_q), .work_o(mul_nxt));
    hilo_div_step #(.W(W)) u_div (.work_i(work_q), .dvsr_i(opnd_q),  .work_o(div_nxt));

    // sign fix-up of the finished iteration
    always_comb begin
        prod = neg_hi_q ? -work_q : work_q;
        quo  = neg_lo_q ? -work_q[W-1:0]   : work_q[W-1:0];
        rem  = neg_hi_q ? -work_q[2*W-1:W] : work_q[2*W-1:W];
        if (is_div_q) begin
            fin_hi = dz_q ? orig_q : rem;
            fin_lo = dz_q ? '1     : quo;
        end else begin
            fin_hi = prod[2*W-1:W];
            fin_lo = prod[W-1:0];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && is_mul)     state_d = ST_MUL;
                else if (accept && is_dv) state_d = ST_DIV;
            end
            ST_MUL, ST_DIV: if (cnt_q == '0) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy = (state_q != ST_IDLE);

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            opnd_q    <= '0;
            orig_q    <= '0;
            work_q    <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            neg_lo_q  <= 1'b0;
            neg_hi_q  <= 1'b0;
            dz_q      <= 1'b0;
            is_div_q  <= 1'b0;
            pend_q    <= 1'b0;
            pend_hi_q <= 1'b0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    if (is_mul) begin
                        work_q   <= {{W{1'b0}}, abs_b};
                        opnd_q   <= abs_a;
                        neg_hi_q <= sign_x;
                        is_div_q <= 1'b0;
                        cnt_q    <= CW'(W-1);
                    end else if (is_dv) begin
                        work_q   <= {{W{1'b0}}, abs_a};
                        opnd_q   <= abs_b;
                        neg_lo_q <= sign_x;
                        neg_hi_q <= sgn && op_a[W-1];
                        dz_q     <= (op_b == '0);
                        orig_q   <= op_a;
                        is_div_q <= 1'b1;
                        cnt_q    <= CW'(W-1);
                    end else if (cmd_func == F_MTHI) begin
                        hi_q <= op_a;
                    end else if (cmd_func == F_MTLO) begin
                        lo_q <= op_a;
                    end else if (mf_any) begin
                        rd_data  <= mf_hi ? hi_q : lo_q;
                        rd_valid <= 1'b1;
                    end
                end
                ST_MUL, ST_DIV: begin
                    work_q <= (state_q == ST_MUL) ? mul_nxt : div_nxt;
                    cnt_q  <= cnt_q - CW'(1);
                    if (cmd_valid && mf_any && !pend_q) begin
                        pend_q    <= 1'b1;
                        pend_hi_q <= mf_hi;
                    end
                end
                ST_FIN: begin
                    hi_q   <= fin_hi;
                    lo_q   <= fin_lo;
                    pend_q <= 1'b0;
                    if (pend_q) begin
                        rd_data  <= pend_hi_q ? fin_hi : fin_lo;
                        rd_valid <= 1'b1;
                    end else if (cmd_valid && mf_any) begin
                        rd_data  <= mf_hi ? fin_hi : fin_lo;
                        rd_valid <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk
    import hilo_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic [5:0]   cmd_func,
    input logic         busy,
    input logic         rd_valid,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 8'd1;
        else           run_q <= '0;
    end

    // R8: an accepted multiply or divide raises busy
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_func[5:2] == 4'b0110)) |=> busy);

    // R8: busy never runs longer than the iteration count plus the finish cycle
    p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 8'(W + 1));

    // R7: move-from HI in idle answers on the next cycle with HI
    p_mfhi_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_func == F_MFHI) |=> (rd_valid && rd_data == $past(hi_q)));

    // R7: move-from LO in idle answers on the next cycle with LO
    p_mflo_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_func == F_MFLO) |=> (rd_valid && rd_data == $past(lo_q)));

    // R12: idle without a command keeps HI and LO
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !busy) |=> ($stable(hi_q) && $stable(lo_q)));

    // R10: HI and LO only change on the cycle busy falls, while an operation runs
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && busy) |-> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/hilo_muldiv_test.sv
module hilo_muldiv_test;
    import hilo_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_func = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [31:0] rd_data;
    logic        rd_valid, busy;

    int checks = 0, errors = 0;
    logic [31:0] m_hi = '0, m_lo = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    hilo_muldiv #(.W(32)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
        .op_a(op_a), .op_b(op_b), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard on every result
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected result actual=%h expected=none", rd_data);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic push(input logic [31:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = f; op_a = a; op_b = b;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_func = '0; op_a = '0; op_b = '0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic read_both(input string tag);
        push(m_hi, {tag, " HI"});
        issue(F_MFHI, '0, '0);
        push(m_lo, {tag, " LO"});
        issue(F_MFLO, '0, '0);
        @(negedge clk);
    endtask

    task automatic model(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        longint      q, r;
        case (f)
            F_MULT:  begin p = longint'($signed(a)) * longint'($signed(b)); m_hi = p[63:32]; m_lo = p[31:0]; end
            F_MULTU: begin p = {32'b0, a} * {32'b0, b}; m_hi = p[63:32]; m_lo = p[31:0]; end
            F_DIV, F_DIVU: begin
                if (b == 0) begin m_lo = '1; m_hi = a; end
                else if (f == F_DIV) begin
                    q = longint'($signed(a)) / longint'($signed(b));
                    r = longint'($signed(a)) % longint'($signed(b));
                    m_lo = q[31:0]; m_hi = r[31:0];
                end else begin m_lo = a / b; m_hi = a % b; end
            end
            default: ;
        endcase
    endtask

    task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input string tag);
        int n;
        model(f, a, b);
        issue(f, a, b);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk({tag, " R8 busy length"}, n, 33);
        read_both(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", {31'b0, busy}, 0);
        chk("R1 rd_valid after reset", {31'b0, rd_valid}, 0);
        read_both("R1 reset value");

        run_op(F_MULT,  32'hFFFF_FFFD, 32'h0000_0007, "R2 neg*pos");
        run_op(F_MULT,  32'h8000_0000, 32'h8000_0000, "R2 min*min");
        run_op(F_MULT,  32'h1234_5678, 32'hFEDC_BA98, "R2 mixed");
        run_op(F_MULTU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 ones*ones");
        run_op(F_MULTU, 32'h1234_5678, 32'hFEDC_BA98, "R3 mixed");
        run_op(F_DIV,   32'd7,         32'd2,         "R4 +/+");
        run_op(F_DIV,   32'hFFFF_FFF9, 32'd2,         "R4 -/+");
        run_op(F_DIV,   32'd7,         32'hFFFF_FFFE, "R4 +/-");
        run_op(F_DIV,   32'hFFFF_FFF9, 32'hFFFF_FFFE, "R4 -/-");
        run_op(F_DIV,   32'h8000_0000, 32'hFFFF_FFFF, "R4 min/-1");
        run_op(F_DIVU,  32'hFFFF_FFF9, 32'd10,        "R5 large");
        run_op(F_DIVU,  32'd5,         32'd9,         "R5 small");
        run_op(F_DIV,   32'hFFFF_FF00, 32'd0,         "R6 signed by zero");
        run_op(F_DIVU,  32'h0000_1234, 32'd0,         "R6 unsigned by zero");

        // R7: move-to
        issue(F_MTHI, 32'hCAFE_0001, 32'h1);
        m_hi = 32'hCAFE_0001;
        issue(F_MTLO, 32'hBEEF_0002, 32'h2);
        m_lo = 32'hBEEF_0002;
        read_both("R7 move-to");

        // R9 and R10: reads and writes during an operation
        model(F_MULTU, 32'h0001_0003, 32'h0002_0005);
        push(m_lo, "R9 held read LO");
        issue(F_MULTU, 32'h0001_0003, 32'h0002_0005);
        issue(F_MFLO, '0, '0);
        issue(F_MTHI, 32'h5555_5555, '0);
        issue(F_DIVU, 32'd100, 32'd3);
        issue(F_MTLO, 32'hAAAA_AAAA, '0);
        wait_idle();
        @(negedge clk);
        chk("R9 held read delivered", exp_q.size(), 0);
        read_both("R10 ignored while busy");

        // R11: unknown code; R12: idle hold
        issue(6'b101010, 32'h1111_1111, 32'h2222_2222);
        issue(6'b000000, 32'h3333_3333, 32'h4444_4444);
        repeat (5) @(negedge clk);
        read_both("R11 R12 unchanged");

        repeat (3) @(negedge clk);
        chk("R9 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule